// File: doc/BRIEF.md
# Heterogeneous Core Selection Unit

This block decides which of four cores sharing one instruction set should run the next scheduling interval. The cores differ in width: core 0 is the narrowest and core 3 the widest. For each core the block is given an estimate of throughput, in instructions per second (IPS), and an estimate of power. A one-bit objective input selects how the choice is made. The energy objective picks the core that spends the least energy per instruction. The energy-delay objective picks the core with the highest IPS squared per watt.

A candidate is ranked only after it clears a throughput floor. The floor is set relative to the widest core's estimate and depends on the objective. A start pulse freezes the estimates and the objective, and the block then visits one core per clock. When the visit of the last core is complete, it raises a one-cycle done strobe together with the winning index. All comparisons use cross-multiplication, so the block has no divider.

Top module: `core_sel`

## Requirements
- R1: With objective = 0 (energy), core i qualifies only when 10·IPS_i ≥ 9·IPS_3. IPS_i is bits [16·i +: 16] of `ips_bus`.
- R2: With objective = 0, the winner is the qualifying core with the lowest power/IPS, judged by PWR_i·IPS_b < PWR_b·IPS_i. PWR_i is bits [12·i +: 12] of `pwr_bus`.
- R3: With objective = 1 (energy-delay), core i qualifies only when 2·IPS_i ≥ IPS_3.
- R4: With objective = 1, the winner is the qualifying core with the highest IPS²/power, judged by IPS_i²·PWR_b > IPS_b²·PWR_i.
- R5: When two qualifying cores score equally, the lower index wins.
- R6: Core 3 always qualifies, so it is selected when no narrower core clears the floor.
- R7: After a start is accepted at a rising edge, `done` is high for exactly one cycle following the 5th rising edge after it, and it stays low in between.
- R8: The estimates and the objective are captured at the accepted start. Changes to them, and start pulses, during a scan do not affect the result and produce no extra `done`.
- R9: While reset is asserted, and after it, `done` = 0 and `sel_idx` = 0 until the first decision completes.
- R10: `sel_idx` keeps its last decision until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin a decision; accepted only when no scan is running |
| objective | input | 1 | 0 = minimum energy, 1 = best energy-delay |
| ips_bus | input | 64 | Four 16-bit throughput estimates, core i at [16·i +: 16] |
| pwr_bus | input | 48 | Four 12-bit power estimates, core i at [12·i +: 12] |
| done | output | 1 | One-cycle strobe: a decision is available |
| sel_idx | output | 2 | Index of the selected core |

## Verification
The bound checker tracks accepted starts with its own counter. On every cycle it confirms that `done` appears exactly five edges after an accepted start and at no other time. It also confirms that the strobe is a single cycle wide and that `sel_idx` never moves without a strobe. Only the bench's scenarios can show which core is chosen: the floors at their exact boundaries, the ranking under each objective, ties, the fallback to core 3, and the freezing of inputs when they change in the middle of a scan.

// File: rtl/core_sel_pkg.sv
package core_sel_pkg;

  typedef enum logic {
    OBJ_ENERGY = 1'b0,
    OBJ_EDP    = 1'b1
  } objective_e;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

endpackage

// File: rtl/core_sel_rst_sync.sv
module core_sel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/core_sel_ctrl.sv
module core_sel_ctrl
  import core_sel_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = $clog2(NUM_CORES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             capture,
  output logic             step_vld,
  output logic [IDX_W-1:0] step_idx,
  output logic             step_last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign capture   = start && (state_q == SCAN_IDLE);
  assign step_vld  = (state_q == SCAN_RUN);
  assign step_idx  = cnt_q;
  assign step_last = step_vld && (cnt_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SCAN_IDLE: begin
        if (start) begin
          state_d = SCAN_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SCAN_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST_IDX) begin
          state_d = SCAN_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/core_sel_qualify.sv
module core_sel_qualify
  import core_sel_pkg::*;
#(
  parameter int IPS_W       = 16,
  parameter int FLOOR_W     = 4,
  parameter int E_FLOOR_NUM = 9,
  parameter int E_FLOOR_DEN = 10,
  parameter int D_FLOOR_NUM = 1,
  parameter int D_FLOOR_DEN = 2,
  localparam int QW = IPS_W + FLOOR_W
) (
  input  objective_e       objective,
  input  logic [IPS_W-1:0] ips_cand,
  input  logic [IPS_W-1:0] ips_ref,
  input  logic             cand_is_ref,
  output logic             qualifies
);

  localparam logic [QW-1:0] E_NUM = QW'(E_FLOOR_NUM);
  localparam logic [QW-1:0] E_DEN = QW'(E_FLOOR_DEN);
  localparam logic [QW-1:0] D_NUM = QW'(D_FLOOR_NUM);
  localparam logic [QW-1:0] D_DEN = QW'(D_FLOOR_DEN);

  logic [QW-1:0] cand_ext, ref_ext;
  logic [QW-1:0] lhs, rhs;
  logic [QW-1:0] scale_cand, scale_ref;

  assign cand_ext = QW'(ips_cand);
  assign ref_ext  = QW'(ips_ref);

  always_comb begin
    if (objective == OBJ_ENERGY) begin
      scale_cand = E_DEN;
      scale_ref  = E_NUM;
    end else begin
      scale_cand = D_DEN;
      scale_ref  = D_NUM;
    end
  end

  assign lhs = cand_ext * scale_cand;
  assign rhs = ref_ext * scale_ref;

  // The reference core clears its own floor by definition.
  assign qualifies = cand_is_ref || (lhs >= rhs);

endmodule

// File: rtl/core_sel_rank.sv
module core_sel_rank
  import core_sel_pkg::*;
#(
  parameter int IPS_W = 16,
  parameter int PWR_W = 12,
  localparam int EW = IPS_W + PWR_W,
  localparam int DW = 2 * IPS_W + PWR_W
) (
  input  objective_e       objective,
  input  logic [IPS_W-1:0] ips_cand,
  input  logic [PWR_W-1:0] pwr_cand,
  input  logic [IPS_W-1:0] ips_best,
  input  logic [PWR_W-1:0] pwr_best,
  output logic             strictly_better
);

  logic          better_energy, better_edp;
  logic [EW-1:0] e_lhs, e_rhs;
  logic [DW-1:0] d_lhs, d_rhs;
  logic [DW-1:0] ic_d, ib_d, pc_d, pb_d;

  // energy per instruction: pwr_c/ips_c < pwr_b/ips_b
  assign e_lhs = EW'(pwr_cand) * EW'(ips_best);
  assign e_rhs = EW'(pwr_best) * EW'(ips_cand);
  assign better_energy = e_lhs < e_rhs;

  // ips^2 per watt: ips_c^2/pwr_c > ips_b^2/pwr_b
  assign ic_d  = DW'(ips_cand);
  assign ib_d  = DW'(ips_best);
  assign pc_d  = DW'(pwr_cand);
  assign pb_d  = DW'(pwr_best);
  assign d_lhs = ic_d * ic_d * pb_d;
  assign d_rhs = ib_d * ib_d * pc_d;
  assign better_edp = d_lhs > d_rhs;

  assign strictly_better = (objective == OBJ_ENERGY) ? better_energy : better_edp;

endmodule

// File: rtl/core_sel.sv
module core_sel
  import core_sel_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IPS_W     = 16,
  parameter int PWR_W     = 12,
  localparam int IDX_W    = $clog2(NUM_CORES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       objective,
  input  logic [NUM_CORES*IPS_W-1:0] ips_bus,
  input  logic [NUM_CORES*PWR_W-1:0] pwr_bus,
  output logic                       done,
  output logic [IDX_W-1:0]           sel_idx
);

  localparam logic [IDX_W-1:0] REF_IDX = IDX_W'(NUM_CORES - 1);

  logic             rst_ni;
  logic             capture, step_vld, step_last;
  logic [IDX_W-1:0] step_idx;

  logic [IPS_W-1:0] ips_q [NUM_CORES];
  logic [PWR_W-1:0] pwr_q [NUM_CORES];
  objective_e       obj_q;

  logic [IPS_W-1:0] ips_cur;
  logic [PWR_W-1:0] pwr_cur;
  logic             cur_ok, cur_better, take;

  logic             best_vld_q, best_vld_d;
  logic [IPS_W-1:0] best_ips_q, best_ips_d;
  logic [PWR_W-1:0] best_pwr_q, best_pwr_d;
  logic [IDX_W-1:0] best_idx_q, best_idx_d;
  logic             best_en;

  logic             done_q, done_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             sel_en;

  core_sel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  core_sel_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ni),
    .start     (start),
    .capture   (capture),
    .step_vld  (step_vld),
    .step_idx  (step_idx),
    .step_last (step_last)
  );

  // Snapshot of the estimates, taken only on an accepted start.
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_snap
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        ips_q[g] <= '0;
        pwr_q[g] <= '0;
      end else if (capture) begin
        ips_q[g] <= ips_bus[g*IPS_W +: IPS_W];
        pwr_q[g] <= pwr_bus[g*PWR_W +: PWR_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      obj_q <= OBJ_ENERGY;
    else if (capture) obj_q <= objective_e'(objective);
  end

  assign ips_cur = ips_q[step_idx];
  assign pwr_cur = pwr_q[step_idx];

  core_sel_qualify #(.IPS_W(IPS_W)) u_qual (
    .objective   (obj_q),
    .ips_cand    (ips_cur),
    .ips_ref     (ips_q[NUM_CORES-1]),
    .cand_is_ref (step_idx == REF_IDX),
    .qualifies   (cur_ok)
  );

  core_sel_rank #(.IPS_W(IPS_W), .PWR_W(PWR_W)) u_rank (
    .objective       (obj_q),
    .ips_cand        (ips_cur),
    .pwr_cand        (pwr_cur),
    .ips_best        (best_ips_q),
    .pwr_best        (pwr_best_mux(best_pwr_q)),
    .strictly_better (cur_better)
  );

  function automatic logic [PWR_W-1:0] pwr_best_mux(input logic [PWR_W-1:0] p);
    return p;
  endfunction

  // Strict improvement only, so an equal score keeps the earlier (narrower) core.
  assign take = step_vld && cur_ok && (!best_vld_q || cur_better);

  always_comb begin
    best_en    = 1'b0;
    best_vld_d = best_vld_q;
    best_ips_d = best_ips_q;
    best_pwr_d = best_pwr_q;
    best_idx_d = best_idx_q;
    if (capture) begin
      best_en    = 1'b1;
      best_vld_d = 1'b0;
    end else if (take) begin
      best_en    = 1'b1;
      best_vld_d = 1'b1;
      best_ips_d = ips_cur;
      best_pwr_d = pwr_cur;
      best_idx_d = step_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      best_vld_q <= 1'b0;
      best_ips_q <= '0;
      best_pwr_q <= '0;
      best_idx_q <= '0;
    end else if (best_en) begin
      best_vld_q <= best_vld_d;
      best_ips_q <= best_ips_d;
      best_pwr_q <= best_pwr_d;
      best_idx_q <= best_idx_d;
    end
  end

  always_comb begin
    done_d = step_last;
    sel_en = step_last;
    sel_d  = take ? step_idx : best_idx_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      done_q <= done_d;
      if (sel_en) sel_q <= sel_d;
    end
  end

  assign done    = done_q;
  assign sel_idx = sel_q;

endmodule

// File: rtl/core_sel_chk.sv
module core_sel_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [IDX_W-1:0] sel_idx
);

  // Independent count of edges since an accepted start: 5 means strobe due.
  logic [2:0] age_q, age_d;

  always_comb begin
    if (start && (age_q == 3'd0 || age_q == 3'd5)) age_d = 3'd1;
    else if (age_q != 3'd0 && age_q != 3'd5)       age_d = age_q + 3'd1;
    else                                           age_d = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 3'd0;
    else        age_q <= age_d;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (age_q == 3'd5));

  assert_done_not_missed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd5) |-> done);

  assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sel_idx));

endmodule

bind core_sel core_sel_chk #(.IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_ni),
  .start   (start),
  .done    (done),
  .sel_idx (sel_idx)
);

// File: tb/core_sel_tb.sv
module core_sel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int IW = 16;
  localparam int PW = 12;
  localparam int NV = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic            objective;
  logic [NC*IW-1:0] ips_bus;
  logic [NC*PW-1:0] pwr_bus;
  logic            done;
  logic [1:0]      sel_idx;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_sel u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .objective (objective),
    .ips_bus   (ips_bus),
    .pwr_bus   (pwr_bus),
    .done      (done),
    .sel_idx   (sel_idx)
  );

  // objective, four IPS, four power values, expected winner
  localparam int V_OBJ [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 1, 1};
  localparam int V_IPS [NV][NC] = '{
    '{100, 200, 300, 400},  // R6: only core 3 clears 90%
    '{380, 390, 395, 400},  // R2: all qualify, core 0 cheapest
    '{360, 300, 395, 400},  // R1 boundary on core 0, core 1 fails, R2 core 2
    '{400, 400, 400, 400},  // R5: cores 1 and 2 tie
    '{359, 100, 100, 400},  // R1: just under the floor
    '{200, 250, 300, 400},  // R3 boundary, R4 core 0 best
    '{199, 250, 300, 400},  // R3: core 0 just under
    '{250, 100, 300, 400},  // R1: energy floor leaves core 3
    '{250, 100, 300, 400},  // R4: same data, 50% floor
    '{400, 400, 200, 400}   // R5: four-way tie
  };
  localparam int V_PWR [NV][NC] = '{
    '{10, 20, 30, 40},
    '{10, 20, 30, 40},
    '{36,  1, 30, 40},
    '{40, 20, 20, 40},
    '{ 1,  1,  1, 40},
    '{10, 20, 30, 80},
    '{10, 20, 30, 80},
    '{ 5,  5, 60, 40},
    '{ 5,  5, 60, 40},
    '{40, 40, 10, 40}
  };
  localparam int V_EXP [NV] = '{3, 0, 2, 1, 3, 0, 1, 3, 0, 0};

  function automatic string vec_tag(input int v);
    case (v)
      0: return "R6";
      1: return "R2";
      2: return "R1";
      3: return "R5";
      4: return "R1";
      5: return "R4";
      6: return "R3";
      7: return "R1";
      8: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(input int v, input int obj);
    objective = obj[0];
    for (int c = 0; c < NC; c++) begin
      ips_bus[c*IW +: IW] = IW'(V_IPS[v][c]);
      pwr_bus[c*PW +: PW] = PW'(V_PWR[v][c]);
    end
  endtask

  // Start one decision and check latency, result and strobe width.
  task automatic run_vec(input int v);
    bit early;
    @(negedge clk);
    load(v, V_OBJ[v]);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    early = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < 4 && done) early = 1'b1;
    end
    check(done && !early, "R7 strobe timing", int'(done), 1);
    check(sel_idx == 2'(V_EXP[v]), vec_tag(v), int'(sel_idx), V_EXP[v]);
    @(negedge clk);
    check(!done, "R7 strobe width", int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    objective = 1'b0;
    ips_bus = '0;
    pwr_bus = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done, "R9 reset done", int'(done), 0);
    check(sel_idx == 2'd0, "R9 reset index", int'(sel_idx), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R10: result held with no strobe (last vector chose 0; make it 1 first)
    run_vec(6);
    repeat (5) begin
      @(negedge clk);
      check(sel_idx == 2'd1 && !done, "R10 hold", int'(sel_idx), 1);
    end

    // R8: inputs and start change in mid-scan; result follows the snapshot
    @(negedge clk);
    load(1, 0);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    load(0, 1);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(!done, "R8 no early strobe", int'(done), 0);
    @(negedge clk);
    check(done, "R8 strobe", int'(done), 1);
    check(sel_idx == 2'd0, "R8 snapshot result", int'(sel_idx), 0);
    begin
      int extra = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R8 ignored start", extra, 0);
    end

    // R9: reset in the middle of a scan
    run_vec(0);
    @(negedge clk);
    load(1, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(sel_idx == 2'd0 && !done, "R9 async reset", int'(sel_idx), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check(seen == 0 && sel_idx == 2'd0, "R9 aborted scan", seen, 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule